// File: doc/BRIEF.md
# Wavetable tone generator

The block produces a continuous stream of 16-bit audio samples for a periodic tone. A 24-bit phase accumulator steps by an increment input every time the downstream consumer takes a sample. The top nine bits of the phase select one of 512 waveform words. These words are computed inside the block and are not loaded from outside. A larger increment walks through the waveform faster and gives a higher pitch.

Samples leave on a valid/take stream. A sample is consumed in any cycle where `valid_o` and `take_i` are both high. After each take the block drops `valid_o` for one cycle while the next table word is read, then offers the new sample. The output can drive a serial audio transmitter directly, or through a FIFO or a pipeline register.

Top module: `wavetable_tone_gen`

## Requirements
- R1: While and right after `rst_ni` is low, `valid_o` is 1, the phase is 0 and `sample_o` shows table word 0, which is 0.
- R2: Table word k (0..511) is two's complement: let h = k mod 256, t = h when h < 128, else 255 - h, and v = t * 256. The word is v for k < 256 and -v for k >= 256.
- R3: Words at indices at or above the parameter `DEF_ENTRIES` (default 512) read as zero.
- R4: The phase is 24 bits wide and wraps modulo 2^24. The table index is phase bits [23:15].
- R5: The phase grows by `incr_i` only on a take edge, meaning a rising clock edge with `valid_o` and `take_i` both high.
- R6: `take_i` in a cycle where `valid_o` is low is ignored. The phase does not move and `valid_o` still returns high in the next cycle.
- R7: After a take edge `valid_o` is low for exactly one cycle. It is then high with the word for the new phase.
- R8: While `valid_o` is high and `take_i` is low, `sample_o` and `valid_o` hold.
- R9: A new `incr_i` value is used at the next take edge, with no reset of the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| incr_i | input | 24 | Phase increment per taken sample |
| take_i | input | 1 | Consumer takes the offered sample |
| valid_o | output | 1 | Sample on `sample_o` is valid |
| sample_o | output | 16 | Current waveform sample, two's complement |

## Verification
A take and a change of the increment can land on the same edge. The phase step must then use the increment present at that edge, and the old phase must not be reset. A take can also arrive while `valid_o` is low during the settling cycle, so an ignored take meets the restoration of `valid_o`. The bench provokes both by changing `incr_i` and driving `take_i` from a random pattern. Every cycle it compares `valid_o` and every valid sample against a behavioural model of the phase and the waveform formula. Sweeps with large increments and near-wrap increments carry the index past 448, into the zero region set by a reduced `DEF_ENTRIES`, and across the 2^24 wrap.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic {
    ST_READY  = 1'b0,
    ST_SETTLE = 1'b1
  } wt_state_e;
endpackage

// File: rtl/wt_phase_acc.sv
module wt_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic [PHASE_W-1:0] incr_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q;

  // wraps naturally modulo 2^PHASE_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (adv_i) phase_q <= phase_q + incr_i;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/wt_rom.sv
module wt_rom #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int DEF_ENTRIES = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int TRI_W = ADDR_W - 2;
  localparam int SH    = DATA_W - 1 - TRI_W;
  localparam logic [ADDR_W:0] DEF_L = (ADDR_W+1)'(DEF_ENTRIES);

  logic [ADDR_W-1:0] addr_q;
  logic [TRI_W-1:0]  tri_w;
  logic [DATA_W-1:0] mag_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_i;
  end

  // triangle per half period, sign from the top index bit
  always_comb begin
    tri_w = addr_q[ADDR_W-2] ? ~addr_q[TRI_W-1:0] : addr_q[TRI_W-1:0];
    mag_w = {1'b0, tri_w, {SH{1'b0}}};
    if ({1'b0, addr_q} >= DEF_L)   data_o = '0;
    else if (addr_q[ADDR_W-1])     data_o = -mag_w;
    else                           data_o = mag_w;
  end
endmodule

// File: rtl/wt_stream_ctl.sv
module wt_stream_ctl
  import wt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic valid_o,
  output logic adv_o
);
  wt_state_e state_q, state_d;

  assign valid_o = (state_q == ST_READY);
  assign adv_o   = valid_o & take_i;

  always_comb begin
    state_d = ST_READY;
    if (adv_o) state_d = ST_SETTLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_READY;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/wavetable_tone_gen.sv
module wavetable_tone_gen #(
  parameter int PHASE_W     = 24,
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 16,
  parameter int DEF_ENTRIES = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] incr_i,
  input  logic               take_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  sample_o
);
  logic               adv_w;
  logic [PHASE_W-1:0] phase_w;

  wt_stream_ctl i_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (take_i),
    .valid_o (valid_o),
    .adv_o   (adv_w)
  );

  wt_phase_acc #(.PHASE_W(PHASE_W)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv_w),
    .incr_i  (incr_i),
    .phase_o (phase_w)
  );

  wt_rom #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .DEF_ENTRIES (DEF_ENTRIES)
  ) i_rom (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (phase_w[PHASE_W-1 -: ADDR_W]),
    .data_o (sample_o)
  );
endmodule

// File: rtl/wt_tone_chk.sv
module wt_tone_chk #(
  parameter int PHASE_W = 24,
  parameter int DATA_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [PHASE_W-1:0] incr_i,
  input logic               take_i,
  input logic               valid_o,
  input logic [DATA_W-1:0]  sample_o,
  input logic [PHASE_W-1:0] phase_w
);
  assert_settle_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && take_i) |=> !valid_o);

  assert_settle_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !take_i) |=> (valid_o && $stable(sample_o)));

  assert_ignore_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |=> $stable(phase_w));

  assert_no_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(phase_w));

  assert_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && take_i) |=> (phase_w == PHASE_W'($past(phase_w) + $past(incr_i))));
endmodule

bind wavetable_tone_gen wt_tone_chk #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .incr_i   (incr_i),
  .take_i   (take_i),
  .valid_o  (valid_o),
  .sample_o (sample_o),
  .phase_w  (phase_w)
);

// File: tb/test_wavetable_tone_gen.sv
`timescale 1ns/1ps
module test_wavetable_tone_gen;
  localparam int DEF = 448;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] incr_i = '0;
  logic        take_i = 1'b0;
  logic        valid_o;
  logic [15:0] sample_o;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  longint m_phase = 0;
  bit     m_valid = 1;

  always #10 clk_i = ~clk_i;

  wavetable_tone_gen #(.DEF_ENTRIES(DEF)) i_wavetable_tone_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .incr_i   (incr_i),
    .take_i   (take_i),
    .valid_o  (valid_o),
    .sample_o (sample_o)
  );

  function automatic logic [15:0] wave(input int k);
    int h, t, v;
    if (k >= DEF) return 16'h0000;    // R3
    h = k % 256;
    t = (h < 128) ? h : 255 - h;
    v = t * 256;
    if (k >= 256) v = -v;             // R2
    return v[15:0];
  endfunction

  task automatic compare();
    int idx;
    n_chk++;
    if (valid_o !== m_valid) begin
      n_err++;
      $display("FAIL %s valid: actual=%0b expected=%0b", tag, valid_o, m_valid);
    end
    if (m_valid) begin
      idx = int'(m_phase >> 15);
      n_chk++;
      if (sample_o !== wave(idx)) begin
        n_err++;
        $display("FAIL %s %s sample idx=%0d: actual=%h expected=%h", tag,
                 (idx >= DEF) ? "R3" : "R2", idx, sample_o, wave(idx));
      end
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    if (m_valid && take_i) begin
      m_phase = (m_phase + longint'(incr_i)) & 64'hFF_FFFF;  // R4 wrap
      m_valid = 0;
    end else begin
      m_valid = 1;
    end
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    #4_000_000;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk_i);
    tag = "R1";
    compare();
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare();

    // R8 hold with no take
    tag = "R8";
    incr_i = 24'h00_8000;
    for (int i = 0; i < 10; i++) step();

    // R5 R7 continuous take, one entry per sample
    tag = "R7";
    take_i = 1'b1;
    for (int i = 0; i < 300; i++) step();

    // R6 random take, including takes during the settle cycle
    tag = "R6";
    for (int i = 0; i < 600; i++) begin
      take_i = $urandom_range(0, 1);
      step();
    end

    // R9 increment changes on take edges, phase kept
    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      if (i % 7 == 0) incr_i = 24'($urandom_range(1, 24'h3F_FFFF));
      take_i = (i % 3 != 2);
      step();
    end

    // R4 wrap with near-2^24 increment (phase walks backwards)
    tag = "R4";
    incr_i = 24'hFF_F000;
    take_i = 1'b1;
    for (int i = 0; i < 600; i++) step();
    incr_i = 24'hC0_0001;
    for (int i = 0; i < 200; i++) step();

    // R3 R5 sweep through the whole index range, zero region included
    tag = "R3";
    incr_i = 24'h03_8000;
    for (int i = 0; i < 800; i++) begin
      take_i = (i % 5 != 4);
      step();
    end

    tag = "R8";
    take_i = 1'b0;
    for (int i = 0; i < 8; i++) step();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule